// File: doc/BRIEF.md
# Bit-Transparent Synchronous Serial Transmitter

This block turns a stream of data words into a raw serial bit stream with no framing, no start or stop bits and no protocol overhead. Each word is cut to a programmable character length of 4 to 16 bits. It goes out least-significant bit first, or most-significant bit first when the reverse option is set. When it has no message to send, the line carries idle characters of all ones.

A message is released only after a synchronization event. In pin mode that event is a pulse on a sync input. In time-division mode it is a frame-sync pulse, and after it the bit clock of the block advances only during cycles where its slot enable is high. A message starts only on a character boundary, so the pending-buffer flag is in effect polled once per character time. Words arrive through a valid/take handshake that carries an end-of-buffer mark, with a buffer-ready flag and a last-buffer flag beside it. A one-cycle done pulse with an underrun status closes each buffer. A buffer without the last flag chains straight into the next one, with no idle gap between them. A continuous mode keeps synchronization across messages, so a later message needs no new sync event.

Top module: `tsync_tx`

## Requirements
- R1: While `en` is low, `txd` is 1, `data_take` is 0 and `done` is 0, whatever the other inputs do.
- R2: While enabled with no message in progress, `txd` carries idle characters, which are all ones.
- R3: The character length is `char_len`. A value below 4 acts as 4 and a value above 16 acts as 16.
- R4: With `msb_first` low, bit 0 of each word goes out first. With `msb_first` high, bit `len-1` goes out first. Only the low `len` bits of the word are sent.
- R5: In pin mode no data word is taken before `sync_in` is seen high at a clock edge. If a buffer is ready and data is valid at that point, the first data bit appears on `txd` after the next edge.
- R6: In time-division mode (`tdm_mode`=1), `frame_sync` is the sync event and `txd` changes only after edges where `slot_en` is high. The first slot bit after the frame sync begins a new character.
- R7: A word is taken (`data_take`=1 together with `data_valid`) only at a character boundary, and every word that is taken goes out once, in order.
- R8: When a word marked `data_eob` is taken with `bd_last` high, `done` pulses for one cycle with `done_underrun`=0 and idles follow. Outside continuous mode, a further ready message waits for a new sync event.
- R9: When a word marked `data_eob` is taken with `bd_last` low, `done` pulses with `done_underrun`=0 and the next buffer's first word follows with no idle bits.
- R10: If `data_valid` is low at a character boundary in the middle of a buffer, an idle character is sent, `done` pulses with `done_underrun`=1, and the block returns to idle.
- R11: With `cont_mode`=1, a message that becomes ready after a finished one starts at the next character boundary without a new sync event.
- R12: A buffer that becomes ready in the middle of an idle character starts only at the next character boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Transmitter enable; low clears all state |
| tdm_mode | input | 1 | 1: frame sync plus slot gating; 0: pin sync |
| cont_mode | input | 1 | Keep synchronization across messages |
| msb_first | input | 1 | Send most-significant bit of the character first |
| char_len | input | 5 | Character length in bits (clamped to 4..16) |
| sync_in | input | 1 | Pin-mode synchronization pulse |
| frame_sync | input | 1 | Time-division frame start pulse |
| slot_en | input | 1 | High during the bits of this channel's time slot |
| bd_ready | input | 1 | A buffer is pending for transmission |
| bd_last | input | 1 | The current buffer ends the message |
| data_valid | input | 1 | `data_word` holds the next word |
| data_eob | input | 1 | `data_word` is the final word of its buffer |
| data_word | input | 16 | Next data word |
| data_take | output | 1 | The word is consumed at this clock edge |
| done | output | 1 | One-cycle pulse when a buffer closes |
| done_underrun | output | 1 | Status with `done`: 1 if the buffer ended on an underrun |
| txd | output | 1 | Serial data out |

## Verification
The bench builds the block with its defaults: a 16-bit data word and a minimum length of 4. It sweeps every character length from 4 to 16 in both bit orders, and each bit on the line is compared with a stream that the bench builds arithmetically from the words. Small dedicated runs cover the remaining behaviour:
- length clamping at both ends;
- time-division gating with a fixed slot pattern;
- a buffer that becomes ready mid-character;
- buffer chaining;
- an underrun;
- the choice between the continuous and the resynchronizing end of a message.

// File: rtl/tsync_tx_pkg.sv
// Package: shared types for the transparent serial transmitter.
package tsync_tx_pkg;
    // Message controller state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;
endpackage

// File: rtl/tsync_tx_gate.sv
// Synchronization and bit-clock gating.
// Produces the bit tick, the restart strobe raised by a sync event, and the
// synced flag. Assumes sync_in and frame_sync are already synchronous to clk.
module tsync_tx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tdm_mode,
    input  logic sync_in,
    input  logic frame_sync,
    input  logic slot_en,
    input  logic clear_sync,
    output logic tick,
    output logic restart,
    output logic synced
);
    logic synced_q;

    // Sync event: the mode-selected pulse seen while not yet synchronized.
    always_comb begin
        restart = en && !synced_q && (tdm_mode ? frame_sync : sync_in);
        tick    = en && !restart && (tdm_mode ? slot_en : 1'b1);
    end

    // Synced flag: set by a sync event, cleared when a message ends outside continuous mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)   synced_q <= 1'b0;
        else if (clear_sync) synced_q <= 1'b0;
        else if (restart)    synced_q <= 1'b1;
    end

    assign synced = synced_q;
endmodule

// File: rtl/tsync_tx_shifter.sv
// Character shift engine.
// At each character boundary it loads a data word or an idle character,
// reversing the bit order when asked, then shifts one bit per tick onto txd.
// Assumes eff_len is already clamped to MIN..DATA_W.
module tsync_tx_shifter #(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              restart,
    input  logic              tick,
    input  logic              load_data,
    input  logic [DATA_W-1:0] data_word,
    input  logic [LEN_W-1:0]  eff_len,
    input  logic              msb_first,
    output logic              boundary,
    output logic              txd
);
    localparam int CNT_W = $clog2(DATA_W);

    logic [DATA_W-1:0] sr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              txd_q;
    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] ordered;
    logic [LEN_W-1:0]  src_idx;

    // Next character: data or idle ones, in the selected bit order.
    always_comb begin
        raw     = load_data ? data_word : '1;
        ordered = raw;
        src_idx = '0;
        if (msb_first) begin
            for (int i = 0; i < DATA_W; i++) begin
                src_idx    = eff_len - LEN_W'(1) - LEN_W'(i);
                ordered[i] = (LEN_W'(i) < eff_len) ? raw[src_idx[CNT_W-1:0]] : 1'b1;
            end
        end
    end

    // Shift register, bit counter and output bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sr_q  <= '1;
            cnt_q <= '0;
            txd_q <= 1'b1;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == '0) begin
                txd_q <= ordered[0];
                sr_q  <= {1'b1, ordered[DATA_W-1:1]};
                cnt_q <= CNT_W'(eff_len - LEN_W'(1));
            end else begin
                txd_q <= sr_q[0];
                sr_q  <= {1'b1, sr_q[DATA_W-1:1]};
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign boundary = (cnt_q == '0);
    assign txd      = txd_q;

    assert_off_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> txd_q);
    assert_hold_without_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en && !tick |=> $stable(txd_q));
endmodule

// File: rtl/tsync_tx_ctrl.sv
// Buffer and message controller.
// Decides at each character boundary whether to take a data word, closes
// buffers with a done pulse and status, and drops synchronization at the end
// of a message unless continuous mode is on. Assumes step is one cycle wide.
module tsync_tx_ctrl
    import tsync_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic step,
    input  logic synced,
    input  logic bd_ready,
    input  logic bd_last,
    input  logic data_valid,
    input  logic data_eob,
    input  logic cont_mode,
    output logic load_data,
    output logic clear_sync,
    output logic done,
    output logic done_underrun
);
    tx_state_e state_q;
    logic      done_q;
    logic      und_q;
    logic      start;
    logic      finish;
    logic      starve;

    // Boundary decisions: start, take, end of message, underrun.
    always_comb begin
        start      = (state_q == ST_IDLE) && bd_ready && synced && data_valid;
        load_data  = step && ((state_q == ST_SEND) ? data_valid : start);
        finish     = load_data && data_eob && bd_last;
        starve     = step && (state_q == ST_SEND) && !data_valid;
        clear_sync = (finish || starve) && !cont_mode;
    end

    // State, done pulse and buffer status.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
            und_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load_data) begin
                state_q <= finish ? ST_IDLE : ST_SEND;
                if (data_eob) begin
                    done_q <= 1'b1;
                    und_q  <= 1'b0;
                end
            end else if (starve) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
                und_q   <= 1'b1;
            end
        end
    end

    assign done          = done_q;
    assign done_underrun = und_q;

    assert_send_needs_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_SEND |-> synced);
    assert_done_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/tsync_tx.sv
// Top: bit-transparent synchronous serial transmitter.
// Clamps the character length, then ties together sync gating, the shift
// engine and the buffer controller. Assumes one clk cycle is one serial bit.
module tsync_tx #(
    parameter  int DATA_W = 16,
    parameter  int MIN_LEN = 4,
    localparam int LEN_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tdm_mode,
    input  logic              cont_mode,
    input  logic              msb_first,
    input  logic [LEN_W-1:0]  char_len,
    input  logic              sync_in,
    input  logic              frame_sync,
    input  logic              slot_en,
    input  logic              bd_ready,
    input  logic              bd_last,
    input  logic              data_valid,
    input  logic              data_eob,
    input  logic [DATA_W-1:0] data_word,
    output logic              data_take,
    output logic              done,
    output logic              done_underrun,
    output logic              txd
);
    logic [LEN_W-1:0] eff_len;
    logic tick, restart, synced, clear_sync, boundary, load_data;

    // Length clamp into the supported range.
    always_comb begin
        if (char_len < LEN_W'(MIN_LEN))     eff_len = LEN_W'(MIN_LEN);
        else if (char_len > LEN_W'(DATA_W)) eff_len = LEN_W'(DATA_W);
        else                                eff_len = char_len;
    end

    tsync_tx_gate gate_i (
        .clk(clk), .rst_n(rst_n), .en(en), .tdm_mode(tdm_mode),
        .sync_in(sync_in), .frame_sync(frame_sync), .slot_en(slot_en),
        .clear_sync(clear_sync), .tick(tick), .restart(restart), .synced(synced)
    );

    tsync_tx_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .en(en), .restart(restart), .tick(tick),
        .load_data(load_data), .data_word(data_word), .eff_len(eff_len),
        .msb_first(msb_first), .boundary(boundary), .txd(txd)
    );

    tsync_tx_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .en(en), .step(tick && boundary),
        .synced(synced), .bd_ready(bd_ready), .bd_last(bd_last),
        .data_valid(data_valid), .data_eob(data_eob), .cont_mode(cont_mode),
        .load_data(load_data), .clear_sync(clear_sync), .done(done),
        .done_underrun(done_underrun)
    );

    assign data_take = load_data;

    assert_take_after_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        data_take |-> synced);
    assert_slot_gating_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en && tdm_mode && !slot_en |=> $stable(txd));
    assert_underrun_sends_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_underrun |-> txd);
endmodule

// File: tb/tsync_tx_tb_top.sv
// Bench: length/order sweep plus directed runs; expected bit stream built arithmetically.
module tsync_tx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, tdm_mode = 1'b0, cont_mode = 1'b0, msb_first = 1'b0;
    logic [4:0]  char_len = 5'd8;
    logic        sync_in = 1'b0, frame_sync = 1'b0, slot_en = 1'b0;
    logic        bd_ready = 1'b0, bd_last = 1'b0, data_valid = 1'b0, data_eob = 1'b0;
    logic [15:0] data_word = '0;
    logic        data_take, done, done_underrun, txd;

    int checks = 0, fails = 0;
    bit expq[$];
    int dmap[int];
    int pos = 0, widx = 0, nprov = 0, frame_ctr = 0;
    bit armed = 1'b0;
    logic [15:0] wv[0:15];
    bit we[0:15];
    bit wl[0:15];

    always #4 clk = ~clk;

    tsync_tx dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .tdm_mode(tdm_mode), .cont_mode(cont_mode),
        .msb_first(msb_first), .char_len(char_len), .sync_in(sync_in),
        .frame_sync(frame_sync), .slot_en(slot_en), .bd_ready(bd_ready),
        .bd_last(bd_last), .data_valid(data_valid), .data_eob(data_eob),
        .data_word(data_word), .data_take(data_take), .done(done),
        .done_underrun(done_underrun), .txd(txd)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive_data();
        data_valid = (widx < nprov);
        data_word  = (widx < 16) ? wv[widx] : '0;
        data_eob   = (widx < 16) ? we[widx] : 1'b0;
        bd_last    = (widx < 16) ? wl[widx] : 1'b0;
    endtask

    task automatic push_word(int len, bit msb, logic [15:0] v, bit e, bit l, bit expect_bits);
        wv[nprov] = v; we[nprov] = e; wl[nprov] = l; nprov++;
        if (expect_bits)
            for (int i = 0; i < len; i++) expq.push_back(msb ? v[len-1-i] : v[i]);
    endtask

    task automatic push_idle(int n);
        for (int i = 0; i < n; i++) expq.push_back(1'b1);
    endtask

    task automatic cycle(string tag);
        bit tk, tk_take;
        logic prev, expb;
        if (tdm_mode) slot_en = ((frame_ctr % 8) >= 3) && ((frame_ctr % 8) <= 6);
        else          slot_en = 1'b0;
        frame_ctr++;
        #1;
        tk = en && (tdm_mode ? slot_en : 1'b1);
        tk_take = data_take;
        prev = txd;
        @(posedge clk); @(negedge clk);
        if (tk_take) begin widx++; drive_data(); end
        if (tk && armed) begin
            expb = (expq.size() > 0) ? expq.pop_front() : 1'b1;
            chk(txd === expb, {tag, " bit"}, int'(txd), int'(expb));
            if (dmap.exists(pos)) begin
                chk(done === 1'b1, {tag, " done"}, int'(done), 1);
                chk(done_underrun === (dmap[pos] == 2), {tag, " status"},
                    int'(done_underrun), int'(dmap[pos] == 2));
            end else begin
                chk(done === 1'b0, {tag, " no done"}, int'(done), 0);
            end
            pos++;
        end else if (tk) begin
            chk(txd === 1'b1, "R2 idle before sync", int'(txd), 1);
            chk(done === 1'b0, "R5 no done before sync", int'(done), 0);
        end else begin
            chk(txd === prev, {tag, " hold"}, int'(txd), int'(prev));
            chk(done === 1'b0, {tag, " no done"}, int'(done), 0);
        end
    endtask

    task automatic start_test(int clen, bit msb, bit tdm, bit cont);
        en = 1'b0; sync_in = 1'b0; frame_sync = 1'b0; slot_en = 1'b0; bd_ready = 1'b0;
        widx = 0; nprov = 0; armed = 1'b0; pos = 0; frame_ctr = 0;
        expq.delete(); dmap.delete();
        drive_data();
        @(posedge clk); @(negedge clk);
        char_len = 5'(clen); msb_first = msb; tdm_mode = tdm; cont_mode = cont;
        en = 1'b1;
    endtask

    task automatic do_sync();
        if (tdm_mode) begin frame_sync = 1'b1; slot_en = 1'b0; end
        else sync_in = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(txd === 1'b1, "R5 line idle at sync", int'(txd), 1);
        frame_sync = 1'b0; sync_in = 1'b0;
        pos = 0; frame_ctr = 1; armed = 1'b1;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin wv[i] = '0; we[i] = 0; wl[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd === 1'b1, "R1 reset txd", int'(txd), 1);
        chk(done === 1'b0, "R1 reset done", int'(done), 0);
        chk(data_take === 1'b0, "R1 reset take", int'(data_take), 0);

        // R1: disabled, with every input pushing to send
        start_test(8, 0, 0, 0);
        en = 1'b0; bd_ready = 1'b1;
        push_word(8, 0, 16'h00A5, 1, 1, 0); drive_data();
        for (int i = 0; i < 6; i++) begin
            sync_in = i[0];
            #1;
            chk(data_take === 1'b0, "R1 take while off", int'(data_take), 0);
            @(posedge clk); @(negedge clk);
            chk(txd === 1'b1, "R1 txd while off", int'(txd), 1);
            chk(done === 1'b0, "R1 done while off", int'(done), 0);
        end

        // R3/R4/R5/R7/R8: sweep of every length and both bit orders
        for (int len = 4; len <= 16; len++) begin
            for (int m = 0; m < 2; m++) begin
                logic [15:0] v0, v1;
                v0 = 16'hA5C3 ^ 16'(len * 16'h1357) ^ 16'(m * 16'h0F0F);
                v1 = 16'h6B19 + 16'(len * 16'h0211) + 16'(m * 16'h3003);
                start_test(len, m[0], 0, 0);
                bd_ready = 1'b1;
                push_word(len, m[0], v0, 0, 0, 1);
                push_word(len, m[0], v1, 1, 1, 1);
                dmap[len] = 1;
                drive_data();
                repeat (3) cycle("R5 pre-sync");
                chk(widx == 0, "R5 no take before sync", widx, 0);
                do_sync();
                repeat (3 * len) cycle("R4 stream");
                chk(widx == 2, "R7 words taken", widx, 2);
            end
        end

        // R3: clamp below and above the range
        start_test(2, 0, 0, 0);
        bd_ready = 1'b1;
        push_word(4, 0, 16'h0006, 1, 1, 1); dmap[0] = 1; drive_data();
        do_sync(); repeat (12) cycle("R3 clamp low");
        start_test(25, 1, 0, 0);
        bd_ready = 1'b1;
        push_word(16, 1, 16'h8E31, 1, 1, 1); dmap[0] = 1; drive_data();
        do_sync(); repeat (40) cycle("R3 clamp high");

        // R6: time-division gating
        start_test(4, 1, 1, 0);
        bd_ready = 1'b1;
        push_word(4, 1, 16'h0009, 0, 0, 1);
        push_word(4, 1, 16'h0004, 1, 1, 1);
        dmap[4] = 1; drive_data();
        repeat (5) cycle("R6 pre-sync");
        do_sync(); repeat (40) cycle("R6 slots");
        chk(widx == 2, "R6 words taken", widx, 2);

        // R12: buffer ready mid-character waits for the boundary
        start_test(7, 0, 0, 0);
        push_word(7, 0, 16'h0055, 1, 1, 0); drive_data();
        do_sync();
        push_idle(7); expq.push_back(1'b1); expq.delete();
        push_idle(7);
        for (int i = 0; i < 7; i++) expq.push_back(wv[0][i]);
        dmap[7] = 1;
        repeat (3) cycle("R12 idle");
        bd_ready = 1'b1;
        repeat (25) cycle("R12 start");

        // R9: chained buffers without gaps
        start_test(8, 0, 0, 0);
        bd_ready = 1'b1;
        push_word(8, 0, 16'h00C3, 0, 0, 1);
        push_word(8, 0, 16'h0071, 1, 0, 1);
        push_word(8, 0, 16'h00E8, 1, 1, 1);
        dmap[8] = 1; dmap[16] = 1; drive_data();
        do_sync(); repeat (40) cycle("R9 chain");
        chk(widx == 3, "R9 words taken", widx, 3);

        // R10: underrun in mid-buffer
        start_test(6, 0, 0, 0);
        bd_ready = 1'b1;
        push_word(6, 0, 16'h0012, 0, 0, 1);
        push_word(6, 0, 16'h002D, 0, 0, 1);
        dmap[12] = 2; drive_data();
        do_sync(); repeat (30) cycle("R10 underrun");
        chk(widx == 2, "R10 words taken", widx, 2);

        // R11: continuous mode keeps sync for the next message
        start_test(5, 0, 0, 1);
        bd_ready = 1'b1;
        push_word(5, 0, 16'h0016, 1, 1, 1);
        push_word(5, 0, 16'h0009, 1, 1, 1);
        dmap[0] = 1; dmap[5] = 1; drive_data();
        do_sync(); repeat (20) cycle("R11 continuous");
        chk(widx == 2, "R11 words taken", widx, 2);

        // R8: without continuous mode the next message waits for a new sync
        start_test(5, 0, 0, 0);
        bd_ready = 1'b1;
        push_word(5, 0, 16'h0016, 1, 1, 1);
        push_word(5, 0, 16'h0009, 1, 1, 0);
        dmap[0] = 1; drive_data();
        do_sync(); repeat (20) cycle("R8 resync");
        chk(widx == 1, "R8 words taken", widx, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule